// File: doc/BRIEF.md
# Snoop-Aware Processor Bus Unit

This unit is the processor side of a cache-coherent system bus. It fetches 32-byte lines as four-beat bursts of 64-bit words. A new beat completes each time the bus sampler sees data-ready. It keeps a small direct-mapped store of line tags, states and data. The processor can write single words into a cached line, and that write marks the line modified.

System logic can raise a back-off request. On the next clock the unit drops any burst in flight and stops driving its address, data and control outputs. While back-off is held, or while an address-hold request keeps the address outputs floated, the system may run an inquire (snoop) cycle with an external address strobe. Two clocks later the unit reports a hit, or a hit to a modified line. A modified line is written back only after back-off is released. The hit-modified flag stays up until one clock after the final beat of that writeback. If the inquire carried an invalidate request, the line is then dropped. After the writeback, the aborted read is issued again from its first beat.

Top module: `snoop_bus_unit`

## Requirements
- R1: While reset is held, the strobe, both output enables, hit, hit-modified and read-done are all low.
- R2: A read request produces a one-cycle address strobe with write low and the line address on bits 31:5. The burst ends on the fourth data-ready after the strobe cycle, and read-done then pulses for one cycle. The filled line holds beat n in word n and is clean.
- R3: In the cycle after back-off is sampled high, the address enable, data enable, strobe and write outputs are low. Any burst in progress is abandoned, and a data-ready in a floated cycle is ignored.
- R4: An inquire strobe is accepted only if back-off was sampled high on that edge and the one before it, or address-hold was sampled high on both of those edges. Any other strobe leaves hit and hit-modified unchanged.
- R5: The hit result of an accepted inquire appears on the outputs in the second cycle after the strobe cycle. The inquire is matched on address bits 31:5, and the index is taken from the low line-address bits.
- R6: An inquire that hits a clean line raises hit but not hit-modified and starts no writeback. If invalidate accompanied the strobe, the line becomes invalid.
- R7: A writeback of a modified line starts only after back-off is sampled low. It begins with a strobe while write is high and the line address is driven. It then sends words 0 to 3, one per data-ready, with the data enable high.
- R8: Hit-modified stays high through the cycle after the last data-ready of the snoop writeback and is low in the cycle after that.
- R9: After the writeback, the line becomes invalid if invalidate accompanied the strobe, and clean otherwise.
- R10: After the snoop writeback, the aborted read gets a new strobe on the same address. It needs all four beats again before read-done.
- R11: A word write to an address whose line is cached overwrites that word and makes the line modified. A word write that misses changes nothing.
- R12: In the cycle after address-hold is sampled high, the address enable is low, and a read burst in progress still completes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| rd_req_i | input | 1 | Request a line read |
| rd_addr_i | input | 27 | Line address of the read (bits 31:5) |
| rd_done_o | output | 1 | One-cycle pulse when a read fill completes |
| st_i | input | 1 | Processor word write |
| st_addr_i | input | 29 | Word address (bits 31:3) |
| st_data_i | input | 64 | Word write data |
| addr_o | output | 27 | Bus line address |
| addr_oe_o | output | 1 | Address output enable |
| ads_o | output | 1 | Bus address strobe |
| wr_o | output | 1 | Cycle is a writeback |
| data_o | output | 64 | Writeback data |
| data_oe_o | output | 1 | Data output enable |
| data_i | input | 64 | Read data |
| rdy_i | input | 1 | Data-ready, completes one beat |
| backoff_i | input | 1 | Back-off request |
| ahold_i | input | 1 | Address-hold request |
| eads_i | input | 1 | External inquire address strobe |
| inv_i | input | 1 | Invalidate request with the inquire |
| inq_addr_i | input | 27 | Inquire line address (bits 31:5) |
| hit_o | output | 1 | Last accepted inquire hit a valid line |
| hitm_o | output | 1 | Inquire hit a modified line, writeback pending |

## Verification
In one cycle, the unit's outputs float for back-off, the system presents an inquire strobe, and a stray data-ready arrives in that same floated cycle. The bench provokes this by offering the strobe and a data-ready at the first floated edge, after 0 to 3 beats of a read have completed. It then checks that the hit result arrives on time. After the writeback, the restarted read must get its own strobe and take all four beats before read-done, so a beat that leaked through or a resume from the abort point would show up. The end of the snoop writeback and the restart of the aborted read also fall next to each other. They are judged by the fall of hit-modified and by the restarted strobe carrying write low and the read address.

// File: rtl/snoop_bus_unit.sv
module snoop_bus_unit #(
  parameter int LINES = 4,
  parameter int DW    = 64
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rd_req_i,
  input  logic [31:5]   rd_addr_i,
  output logic          rd_done_o,
  input  logic          st_i,
  input  logic [31:3]   st_addr_i,
  input  logic [DW-1:0] st_data_i,
  output logic [31:5]   addr_o,
  output logic          addr_oe_o,
  output logic          ads_o,
  output logic          wr_o,
  output logic [DW-1:0] data_o,
  output logic          data_oe_o,
  input  logic [DW-1:0] data_i,
  input  logic          rdy_i,
  input  logic          backoff_i,
  input  logic          ahold_i,
  input  logic          eads_i,
  input  logic          inv_i,
  input  logic [31:5]   inq_addr_i,
  output logic          hit_o,
  output logic          hitm_o
);
  localparam int IW = (LINES > 1) ? $clog2(LINES) : 1;
  localparam int NB = 4;
  localparam logic [1:0] L_INV = 2'd0, L_CLN = 2'd1, L_MOD = 2'd2;

  typedef enum logic [1:0] {A_NONE, A_RD, A_WB} act_e;

  logic [31:5]   tag_q [LINES];
  logic [1:0]    lst_q [LINES];
  logic [DW-1:0] dat_q [LINES][NB];
  logic [DW-1:0] buf_q [NB];

  act_e        act_q;
  logic [1:0]  beat_q;
  logic        ads_q, boff_q, ahold_q, done_q;
  logic        rd_pend, wb_pend, wb_inv;
  logic [IW-1:0] wb_idx;
  logic [31:5] rd_addr_q;
  logic        inq_v, inq_inv, hit_q, hitm_q, hitm_clr;
  logic [31:5] inq_a;

  wire accept = eads_i && ((backoff_i && boff_q) || (ahold_i && ahold_q));

  wire [IW-1:0] lk_idx = inq_a[IW+4:5];
  wire lk_hit = inq_v && lst_q[lk_idx] != L_INV && tag_q[lk_idx] == inq_a;
  wire lk_mod = lk_hit && lst_q[lk_idx] == L_MOD;

  wire [IW-1:0] st_idx = st_addr_i[IW+4:5];
  wire st_hit = st_i && lst_q[st_idx] != L_INV && tag_q[st_idx] == st_addr_i[31:5];

  wire [IW-1:0] rd_idx = rd_addr_q[IW+4:5];
  wire beat_ok = act_q != A_NONE && !ads_q && !boff_q && rdy_i;
  wire last    = beat_ok && beat_q == 2'd3;

  assign addr_o    = (act_q == A_WB) ? tag_q[wb_idx] : rd_addr_q;
  assign addr_oe_o = act_q != A_NONE && !boff_q && !ahold_q;
  assign ads_o     = ads_q && !boff_q;
  assign wr_o      = act_q == A_WB && !boff_q;
  assign data_o    = dat_q[wb_idx][beat_q];
  assign data_oe_o = act_q == A_WB && !boff_q;
  assign hit_o     = hit_q;
  assign hitm_o    = hitm_q;
  assign rd_done_o = done_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q <= A_NONE; beat_q <= '0; ads_q <= 1'b0; boff_q <= 1'b0;
      ahold_q <= 1'b0; done_q <= 1'b0; rd_pend <= 1'b0; wb_pend <= 1'b0;
      wb_inv <= 1'b0; wb_idx <= '0; rd_addr_q <= '0; inq_v <= 1'b0;
      inq_inv <= 1'b0; inq_a <= '0; hit_q <= 1'b0; hitm_q <= 1'b0;
      hitm_clr <= 1'b0;
    end else begin
      boff_q   <= backoff_i;
      ahold_q  <= ahold_i;
      ads_q    <= 1'b0;
      done_q   <= 1'b0;
      hitm_clr <= 1'b0;
      inq_v    <= accept;
      inq_a    <= inq_addr_i;
      inq_inv  <= inv_i;
      if (hitm_clr) hitm_q <= 1'b0;
      if (inq_v) begin
        hit_q <= lk_hit;
        if (lk_mod) begin
          hitm_q  <= 1'b1;
          wb_pend <= 1'b1;
          wb_idx  <= lk_idx;
          wb_inv  <= inq_inv;
        end
      end
      if (rd_req_i && !rd_pend) begin
        rd_pend   <= 1'b1;
        rd_addr_q <= rd_addr_i;
      end
      if (boff_q) begin
        act_q  <= A_NONE;
        beat_q <= '0;
      end else if (act_q == A_NONE) begin
        beat_q <= '0;
        if (wb_pend) begin
          act_q <= A_WB; ads_q <= 1'b1;
        end else if (rd_pend) begin
          act_q <= A_RD; ads_q <= 1'b1;
        end
      end else if (beat_ok) begin
        beat_q <= beat_q + 2'd1;
        if (last) begin
          act_q <= A_NONE;
          if (act_q == A_WB) begin
            wb_pend  <= 1'b0;
            hitm_clr <= 1'b1;
          end else begin
            rd_pend <= 1'b0;
            done_q  <= 1'b1;
          end
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < LINES; i++) lst_q[i] <= L_INV;
    end else begin
      if (last && act_q == A_RD) lst_q[rd_idx] <= L_CLN;
      if (st_hit) lst_q[st_idx] <= L_MOD;
      if (lk_hit && !lk_mod && inq_inv) lst_q[lk_idx] <= L_INV;
      if (last && act_q == A_WB) lst_q[wb_idx] <= wb_inv ? L_INV : L_CLN;
    end
  end

  always_ff @(posedge clk) begin
    if (beat_ok && act_q == A_RD) begin
      buf_q[beat_q] <= data_i;
      if (beat_q == 2'd3) begin
        tag_q[rd_idx] <= rd_addr_q;
        for (int b = 0; b < NB - 1; b++) dat_q[rd_idx][b] <= buf_q[b];
        dat_q[rd_idx][NB-1] <= data_i;
      end
    end
    if (st_hit) dat_q[st_idx][st_addr_i[4:3]] <= st_data_i;
  end

  // R2
  strobe_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ads_o |=> !ads_o);
  // R3
  float_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(backoff_i) |-> !addr_oe_o && !data_oe_o && !ads_o && !wr_o);
  // R4
  inq_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(hit_o) |-> ($past(backoff_i, 2) && $past(backoff_i, 3)) ||
                     ($past(ahold_i, 2) && $past(ahold_i, 3)));
  // R5
  hit_lat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(hit_o) |-> $past(eads_i, 2));
  // R7
  wb_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ads_o && wr_o) |-> !$past(backoff_i));
  // R8
  hitm_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(hitm_o) |-> $past(rdy_i, 2) && $past(wr_o, 2));
  // R12
  ahold_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(ahold_i) |-> !addr_oe_o);
endmodule

// File: tb/snoop_bus_unit_bench.sv
module snoop_bus_unit_bench;
  logic clk = 0, rst_n = 0;
  logic rd_req = 0, st = 0, rdy = 0, backoff = 0, ahold = 0, eads = 0, inv = 0;
  logic [31:5] rd_addr = '0, inq_addr = '0;
  logic [31:3] st_addr = '0;
  logic [63:0] st_data = '0, din = '0;
  logic rd_done, addr_oe, ads, wr, data_oe, hit, hitm;
  logic [31:5] addr;
  logic [63:0] dout;
  int total = 0, fails = 0, cyc = 0;

  always #5 clk = ~clk;

  snoop_bus_unit u_snoop_bus_unit (
    .clk(clk), .rst_n(rst_n), .rd_req_i(rd_req), .rd_addr_i(rd_addr),
    .rd_done_o(rd_done), .st_i(st), .st_addr_i(st_addr), .st_data_i(st_data),
    .addr_o(addr), .addr_oe_o(addr_oe), .ads_o(ads), .wr_o(wr),
    .data_o(dout), .data_oe_o(data_oe), .data_i(din), .rdy_i(rdy),
    .backoff_i(backoff), .ahold_i(ahold), .eads_i(eads), .inv_i(inv),
    .inq_addr_i(inq_addr), .hit_o(hit), .hitm_o(hitm));

  function automatic logic [63:0] memw(logic [31:0] a, int b);
    return {a, 32'hB0B0_0000 + b};
  endfunction

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic step; @(negedge clk); endtask

  task automatic wait_ads;
    for (int n = 0; n < 10 && !ads; n++) step;
  endtask

  task automatic beats(input logic [31:0] a, input bit need_full);
    for (int b = 0; b < 4; b++) begin
      rdy = 1; din = memw(a, b); step;
      rdy = 0;
      if (b < 3 && need_full) chk(rd_done == 0, "R10 early done", rd_done, 0);
    end
    chk(rd_done == 1, "R2 read done after 4 beats", rd_done, 1);
  endtask

  task automatic do_read(input logic [31:0] a);
    rd_req = 1; rd_addr = a[31:5]; step; rd_req = 0;
    wait_ads;
    chk(ads && !wr && addr == a[31:5], "R2 read strobe", {ads, wr, addr}, {2'b10, a[31:5]});
    step;
    beats(a, 0);
    step;
  endtask

  task automatic inquire(input logic [31:0] a, input bit iv);
    ahold = 1; step;
    eads = 1; inv = iv; inq_addr = a[31:5]; step;
    eads = 0; inv = 0; step;
    ahold = 0;
  endtask

  initial begin
    for (;;) begin
      @(posedge clk); cyc++;
      if (cyc > 150000) begin
        fails++; total++;
        $display("FAIL watchdog: actual %0d expected <150000", cyc);
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
      end
    end
  end

  initial begin
    step; step;
    // R1 reset state
    chk(!ads && !addr_oe && !data_oe && !hit && !hitm && !rd_done, "R1 reset outputs",
        {ads, addr_oe, data_oe, hit, hitm, rd_done}, 0);
    rst_n = 1; step;

    for (int i = 0; i < 4; i++)
      for (int m = 0; m < 2; m++)
        for (int v = 0; v < 2; v++) begin
          automatic int g = i * 4 + m * 2 + v;
          automatic int k = (i + m * 2 + v) % 4;
          automatic int w = (i + v) % 4;
          automatic logic [31:0] A = 32'h1000_0000 + g * 32'h100 + i * 32;
          automatic logic [31:0] B = 32'h2000_0000 + g * 32'h100 + ((i + 1) % 4) * 32;
          automatic logic [63:0] S = 64'hDEAD_0000_0000_0000 | g;
          do_read(A);
          if (m) begin
            // R11 write into cached line
            st = 1; st_addr = A[31:3] + w; st_data = S; step; st = 0;
          end
          rd_req = 1; rd_addr = B[31:5]; step; rd_req = 0;
          wait_ads; step;
          for (int b = 0; b < k; b++) begin rdy = 1; din = memw(B, b); step; end
          rdy = 0; backoff = 1; step;
          // R3 floated, stray ready and inquire strobe in the same cycle
          chk(!addr_oe && !data_oe && !ads && !wr, "R3 float", {addr_oe, data_oe, ads, wr}, 0);
          rdy = 1; din = 64'hBAD; eads = 1; inv = v; inq_addr = A[31:5]; step;
          rdy = 0; eads = 0; inv = 0; step;
          // R5 R6 hit result two clocks after strobe
          chk(hit == 1 && hitm == m, "R5 R6 hit result", {hit, hitm}, {1'b1, m[0]});
          for (int h = 0; h < 3; h++) begin
            chk(!ads && !data_oe, "R7 held during backoff", {ads, data_oe}, 0);
            step;
          end
          backoff = 0; step;
          wait_ads;
          if (m) begin
            chk(ads && wr && addr == A[31:5], "R7 writeback strobe", {ads, wr, addr}, {2'b11, A[31:5]});
            step;
            for (int b = 0; b < 4; b++) begin
              automatic logic [63:0] e = (b == w) ? S : memw(A, b);
              chk(data_oe && dout == e, "R7 writeback word", dout, e);
              rdy = 1; step;
            end
            rdy = 0;
            chk(hitm == 1, "R8 hitm one clock after last ready", hitm, 1);
            step;
            chk(hitm == 0, "R8 hitm dropped", hitm, 0);
            wait_ads;
          end
          // R10 restart from first beat (R6: no writeback for clean line)
          chk(ads && !wr && addr == B[31:5], "R10 R6 restarted read", {ads, wr, addr}, {2'b10, B[31:5]});
          step;
          beats(B, 1);
          step;
          inquire(A, 0);
          // R9 R6 line state after snoop
          chk(hit == !v && hitm == 0, "R9 R6 line state", {hit, hitm}, {~v[0], 1'b0});
          step;
          chk(!ads && !hitm, "R6 no further writeback", {ads, hitm}, 0);
        end

    begin
      automatic logic [31:0] C = 32'h3000_0040;
      automatic logic [31:0] D = 32'h3100_0040;
      do_read(C);
      // R11 write miss (same index, other tag) ignored
      st = 1; st_addr = D[31:3]; st_data = 64'h1234; step; st = 0;
      inquire(C, 0);
      chk(hit && !hitm, "R11 write miss ignored", {hit, hitm}, 2'b10);
      inquire(D, 0);
      chk(!hit, "R4 miss inquire", hit, 0);
      // R4 back-off seen for only one clock
      backoff = 1; eads = 1; inq_addr = C[31:5]; step;
      eads = 0; step; step;
      chk(!hit, "R4 single back-off clock ignored", hit, 0);
      backoff = 0; step; step;
      // R4 address-hold seen for only one clock
      ahold = 1; eads = 1; inq_addr = C[31:5]; step;
      eads = 0; ahold = 0; step; step;
      chk(!hit, "R4 single hold clock ignored", hit, 0);
      // R4 strobe with neither condition
      eads = 1; step; eads = 0; step; step;
      chk(!hit, "R4 unqualified strobe ignored", hit, 0);
      // R4 two clocks of back-off accepted
      backoff = 1; step;
      eads = 1; step; eads = 0; step;
      chk(hit, "R4 two back-off clocks accepted", hit, 1);
      backoff = 0; step; step;
      // R12 address-hold during a read
      rd_req = 1; rd_addr = D[31:5]; step; rd_req = 0;
      wait_ads; step;
      chk(addr_oe, "R12 address driven before hold", addr_oe, 1);
      rdy = 1; din = memw(D, 0); ahold = 1; step;
      chk(!addr_oe, "R12 address floated by hold", addr_oe, 0);
      for (int b = 1; b < 4; b++) begin din = memw(D, b); step; end
      rdy = 0; ahold = 0;
      chk(rd_done, "R12 read completes under hold", rd_done, 1);
      step; step;
    end

    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule